// File: doc/BRIEF.md
# USB endpoint mode handshake controller

This block serves one endpoint of a low-speed USB serial interface engine. It holds a 4-bit mode that the host processor writes. For each SETUP, IN or OUT token addressed to the endpoint, it answers with one handshake choice: ignore, NAK, ACK, STALL, or send data. The response is a table lookup on the current mode, the token kind, a control/non-control flag and a STALL bit.

After a successful transfer the block rewrites the mode by itself, so firmware does not have to re-arm or disarm the endpoint between packets. For an IN token, the data response counts as the successful transfer, because host acknowledgment is outside this block. Packet decoding, CRC, bit stuffing, data toggles and the FIFO belong to neighbouring logic.

Top module: `ep_mode_ctrl`

## Requirements
- R1: After reset, `mode` is 0000 and `resp_valid` is 0.
- R2: `resp_valid` is 1 exactly one cycle after a cycle with `tok_valid` high, and 0 otherwise.
  - `tok_kind` encodes 0 = SETUP, 1 = IN, 2 = OUT and 3 = none; kind 3 answers ignore.
  - `resp` encodes 0 = ignore, 1 = NAK, 2 = ACK, 3 = STALL and 4 = send data.
- R3: In mode 0000 and in the reserved modes 0101 and 0111, every token is answered with ignore and the mode is unchanged.
- R4: Mode 0001 answers NAK to IN and OUT. Mode 0011 answers STALL to IN and OUT.
- R5: A SETUP is answered with ACK only on a control endpoint and only in modes 0001, 0010, 0011, 0100, 0110, 1010, 1011, 1110 and 1111.
  - That ACK sets the mode to 0001.
  - Any other SETUP is ignored and leaves the mode unchanged.
- R6: In mode 1001, OUT is answered with ACK and the mode becomes 1000. In mode 1011, OUT is answered with ACK and the mode becomes 0001.
- R7: In mode 1101, IN is answered with send data and the mode becomes 1100. In mode 1111, IN is answered with send data and the mode becomes 1110.
- R8: On a non-control endpoint with `stall_bit` set, IN in mode 1001 and OUT in mode 1101 are answered with STALL. With `stall_bit` clear, or on a control endpoint, both are answered with ignore.
- R9: A mode write takes effect at the next edge. In the same cycle as an automatic update, the write wins; the response still follows the old mode.
- R10: The remaining modes answer IN and OUT as follows:
  - 0010: IN STALL, OUT ACK.
  - 0100: IN ignore, OUT ignore.
  - 0110: IN send data, OUT STALL.
  - 1000: IN ignore, OUT NAK.
  - 1010: IN send data, OUT NAK.
  - 1100: IN NAK, OUT ignore.
  - 1110: IN NAK, OUT ACK.
  - 1111: OUT ACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | Token strobe, one cycle per token |
| tok_kind | input | 2 | Token kind: 0 SETUP, 1 IN, 2 OUT, 3 none |
| mode_we | input | 1 | Host mode write strobe |
| mode_wdata | input | 4 | Host mode value |
| is_ctrl | input | 1 | 1 for a control endpoint |
| stall_bit | input | 1 | STALL bit of a non-control endpoint |
| resp_valid | output | 1 | Response strobe |
| resp | output | 3 | Response: 0 ignore, 1 NAK, 2 ACK, 3 STALL, 4 send data |
| mode | output | 4 | Current mode |

## Verification
On every cycle, the assertions check four behaviours:
- the one-cycle response strobe;
- that a host write wins over an automatic update;
- that the mode holds when there is neither a token nor a write;
- that a disabled or reserved mode never answers anything but ignore.

Only the bench's scenarios show two things: the full response table across modes and token kinds, and each automatic mode transition. The same applies to the STALL-bit substitution and to SETUP acceptance on control versus non-control endpoints.

// File: rtl/ep_mode_ctrl.sv
module ep_mode_ctrl #(
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_valid,
  input  logic [1:0]        tok_kind,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              is_ctrl,
  input  logic              stall_bit,
  output logic              resp_valid,
  output logic [2:0]        resp,
  output logic [MODE_W-1:0] mode
);
  localparam logic [1:0] K_SETUP = 2'd0, K_IN = 2'd1, K_OUT = 2'd2;
  localparam logic [2:0] R_IGN = 3'd0, R_NAK = 3'd1, R_ACK = 3'd2,
                         R_STL = 3'd3, R_DAT = 3'd4;

  logic [2:0] r_in, r_out, r_nxt;
  logic       setup_ok;
  logic [MODE_W-1:0] m_nxt;
  logic       stall_ne;

  assign stall_ne = stall_bit && !is_ctrl;

  always_comb begin
    r_in = R_IGN; r_out = R_IGN; setup_ok = 1'b0;
    case (mode)
      4'b0001: begin r_in = R_NAK; r_out = R_NAK; setup_ok = 1'b1; end
      4'b0010: begin r_in = R_STL; r_out = R_ACK; setup_ok = 1'b1; end
      4'b0011: begin r_in = R_STL; r_out = R_STL; setup_ok = 1'b1; end
      4'b0100: setup_ok = 1'b1;
      4'b0110: begin r_in = R_DAT; r_out = R_STL; setup_ok = 1'b1; end
      4'b1000: r_out = R_NAK;
      4'b1001: begin r_out = R_ACK; r_in = stall_ne ? R_STL : R_IGN; end
      4'b1010: begin r_in = R_DAT; r_out = R_NAK; setup_ok = 1'b1; end
      4'b1011: begin r_in = R_NAK; r_out = R_ACK; setup_ok = 1'b1; end
      4'b1100: r_in = R_NAK;
      4'b1101: begin r_in = R_DAT; r_out = stall_ne ? R_STL : R_IGN; end
      4'b1110: begin r_in = R_NAK; r_out = R_ACK; setup_ok = 1'b1; end
      4'b1111: begin r_in = R_DAT; r_out = R_ACK; setup_ok = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    case (tok_kind)
      K_SETUP: r_nxt = (setup_ok && is_ctrl) ? R_ACK : R_IGN;
      K_IN:    r_nxt = r_in;
      K_OUT:   r_nxt = r_out;
      default: r_nxt = R_IGN;
    endcase
  end

  always_comb begin
    m_nxt = mode;
    if (tok_valid) begin
      if (tok_kind == K_SETUP && setup_ok && is_ctrl) m_nxt = 4'b0001;
      else if (tok_kind == K_OUT && mode == 4'b1001)  m_nxt = 4'b1000;
      else if (tok_kind == K_OUT && mode == 4'b1011)  m_nxt = 4'b0001;
      else if (tok_kind == K_IN  && mode == 4'b1101)  m_nxt = 4'b1100;
      else if (tok_kind == K_IN  && mode == 4'b1111)  m_nxt = 4'b1110;
    end
    if (mode_we) m_nxt = mode_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode       <= '0;
      resp_valid <= 1'b0;
      resp       <= R_IGN;
    end else begin
      mode       <= m_nxt;
      resp_valid <= tok_valid;
      resp       <= tok_valid ? r_nxt : R_IGN;
    end
  end
endmodule

module ep_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tok_valid,
  input logic       mode_we,
  input logic [3:0] mode_wdata,
  input logic       resp_valid,
  input logic [2:0] resp,
  input logic [3:0] mode
);
  a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid == $past(tok_valid));

  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_we) |-> mode == $past(mode_wdata));

  a_r3_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(mode_we) && !$past(tok_valid)) |-> $stable(mode));

  a_r3_off_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tok_valid) && ($past(mode) == 4'b0000 || $past(mode) == 4'b0101 ||
     $past(mode) == 4'b0111)) |-> resp == 3'd0);
endmodule

bind ep_mode_ctrl ep_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .mode_we(mode_we),
  .mode_wdata(mode_wdata), .resp_valid(resp_valid), .resp(resp), .mode(mode)
);

// File: tb/sim_ep_mode_ctrl.sv
module sim_ep_mode_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tok_valid = 1'b0;
  logic [1:0] tok_kind = 2'd3;
  logic mode_we = 1'b0;
  logic [3:0] mode_wdata = 4'd0;
  logic is_ctrl = 1'b1;
  logic stall_bit = 1'b0;
  logic resp_valid;
  logic [2:0] resp;
  logic [3:0] mode;

  localparam logic [1:0] SU = 2'd0, TI = 2'd1, TO = 2'd2;
  localparam logic [2:0] IGN = 3'd0, NAK = 3'd1, ACK = 3'd2, STL = 3'd3, DAT = 3'd4;

  int n_chk = 0, n_bad = 0;

  ep_mode_ctrl u0 (.*);

  always #5 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] m);
    @(negedge clk); mode_we = 1'b1; mode_wdata = m;
    @(negedge clk); mode_we = 1'b0;
  endtask

  task automatic tok(string req, logic [3:0] m, logic [1:0] k, logic [2:0] er, logic [3:0] em);
    wr(m);
    tok_valid = 1'b1; tok_kind = k;
    @(negedge clk); tok_valid = 1'b0; tok_kind = 2'd3;
    chk({req, " valid"}, int'(resp_valid), 1);
    chk({req, " resp"}, int'(resp), int'(er));
    chk({req, " mode"}, int'(mode), int'(em));
  endtask

  task automatic t_reset();
    chk("R1 mode", int'(mode), 0);
    chk("R1 valid", int'(resp_valid), 0);
  endtask

  task automatic t_strobe();
    @(negedge clk);
    chk("R2 idle", int'(resp_valid), 0);
    tok("R2 none kind", 4'b0001, 2'd3, IGN, 4'b0001);
    @(negedge clk);
    chk("R2 drop", int'(resp_valid), 0);
  endtask

  task automatic t_off();
    tok("R3 0000 in", 4'b0000, TI, IGN, 4'b0000);
    tok("R3 0000 setup", 4'b0000, SU, IGN, 4'b0000);
    tok("R3 0101 out", 4'b0101, TO, IGN, 4'b0101);
    tok("R3 0111 setup", 4'b0111, SU, IGN, 4'b0111);
  endtask

  task automatic t_nak_stall();
    tok("R4 0001 in", 4'b0001, TI, NAK, 4'b0001);
    tok("R4 0001 out", 4'b0001, TO, NAK, 4'b0001);
    tok("R4 0011 in", 4'b0011, TI, STL, 4'b0011);
    tok("R4 0011 out", 4'b0011, TO, STL, 4'b0011);
  endtask

  task automatic t_setup();
    tok("R5 1111 setup", 4'b1111, SU, ACK, 4'b0001);
    tok("R5 0110 setup", 4'b0110, SU, ACK, 4'b0001);
    tok("R5 1001 setup", 4'b1001, SU, IGN, 4'b1001);
    is_ctrl = 1'b0;
    tok("R5 nonctrl setup", 4'b1010, SU, IGN, 4'b1010);
    is_ctrl = 1'b1;
  endtask

  task automatic t_out_auto();
    tok("R6 1001 out", 4'b1001, TO, ACK, 4'b1000);
    tok("R6 1011 out", 4'b1011, TO, ACK, 4'b0001);
  endtask

  task automatic t_in_auto();
    tok("R7 1101 in", 4'b1101, TI, DAT, 4'b1100);
    tok("R7 1111 in", 4'b1111, TI, DAT, 4'b1110);
  endtask

  task automatic t_stall_bit();
    is_ctrl = 1'b0; stall_bit = 1'b1;
    tok("R8 1001 in stall", 4'b1001, TI, STL, 4'b1001);
    tok("R8 1101 out stall", 4'b1101, TO, STL, 4'b1101);
    stall_bit = 1'b0;
    tok("R8 1001 in clear", 4'b1001, TI, IGN, 4'b1001);
    is_ctrl = 1'b1; stall_bit = 1'b1;
    tok("R8 1101 out ctrl", 4'b1101, TO, IGN, 4'b1101);
    stall_bit = 1'b0;
  endtask

  task automatic t_write_wins();
    wr(4'b1001);
    mode_we = 1'b1; mode_wdata = 4'b0100; tok_valid = 1'b1; tok_kind = TO;
    @(negedge clk);
    mode_we = 1'b0; tok_valid = 1'b0; tok_kind = 2'd3;
    chk("R9 resp", int'(resp), int'(ACK));
    chk("R9 mode", int'(mode), 4);
  endtask

  task automatic t_others();
    tok("R10 0010 in", 4'b0010, TI, STL, 4'b0010);
    tok("R10 0010 out", 4'b0010, TO, ACK, 4'b0010);
    tok("R10 0100 out", 4'b0100, TO, IGN, 4'b0100);
    tok("R10 0110 in", 4'b0110, TI, DAT, 4'b0110);
    tok("R10 0110 out", 4'b0110, TO, STL, 4'b0110);
    tok("R10 1000 in", 4'b1000, TI, IGN, 4'b1000);
    tok("R10 1000 out", 4'b1000, TO, NAK, 4'b1000);
    tok("R10 1010 in", 4'b1010, TI, DAT, 4'b1010);
    tok("R10 1010 out", 4'b1010, TO, NAK, 4'b1010);
    tok("R10 1100 in", 4'b1100, TI, NAK, 4'b1100);
    tok("R10 1100 out", 4'b1100, TO, IGN, 4'b1100);
    tok("R10 1110 in", 4'b1110, TI, NAK, 4'b1110);
    tok("R10 1110 out", 4'b1110, TO, ACK, 4'b1110);
    tok("R10 1111 out", 4'b1111, TO, ACK, 4'b1111);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_strobe();
    t_off();
    t_nak_stall();
    t_setup();
    t_out_auto();
    t_in_auto();
    t_stall_bit();
    t_write_wins();
    t_others();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule